// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

The allocator sits between decode and dispatch. Each cycle it looks at an ordered window of up to eight decoded instruction descriptors. It packs the longest prefix of that window that obeys two sets of rules into a single dispatch group. The first set covers slot occupancy: a single takes one slot, a pair takes an even-aligned slot pair, and a whole-group op takes all eight slots. The second set covers issue-port caps: four execution units, two load units and two store units. Instructions are considered strictly in program order. The group closes at the first instruction that does not fit, even if a later one would.

The number of instructions taken is presented combinationally in the same cycle as the window, so the upstream queue can pop them. The group itself is registered: one cycle after acceptance, the block shows which slots are occupied, which window entry owns each slot, and which issue units each accepted instruction was given.

Top module: `disp_group_alloc`

## Requirements
- R1: A synchronous active-high reset clears the registered group: grpValid, grpSlotValid, grpSlotIdx and grpUnit read zero on the next edge.
- R2: takeCount is combinational, is never larger than winCount, and is zero while dispReady is low. Only the first winCount entries of the window are considered.
- R3: Slot class codes are 0 = single, 1 = pair, 2 = whole group, and 3 behaves as single. A single takes the next free slot, and grpSlotIdx of every occupied slot gives the window index of its owner.
- R4: A pair starts at the next even slot, leaving an odd slot empty if needed. If no aligned pair remains, the group closes.
- R5: A whole-group op is accepted only as the first instruction of the group and then occupies all eight slots. Otherwise the group closes before it.
- R6: Resource codes 0, 6 and 7 each need one execution unit. At most four are used per group, handed out lowest index first. The grpUnit bit layout is [3:0] execution units 0..3, [5:4] load units 0..1 and [7:6] store units 0..1, and no unit is given to two instructions.
- R7: Resource code 1 needs execution units 0+1 together, or else 2+3. If neither pair is free, the group closes.
- R8: Code 2 needs one load unit, with at most two per group. Code 3 needs one load unit plus one store unit.
- R9: Code 4 needs one store unit. Code 5 needs both store units, which must both be free.
- R10: The group closes at the first instruction that breaks a rule, and no later instruction is taken in that cycle.
- R11: With dispReady high and winCount non-zero, at least one instruction is always taken.
- R12: The registered group appears one cycle after acceptance. grpValid is low, with no slots or units shown, after a cycle in which nothing was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| winCount | input | 4 | Number of valid leading window entries (0..8) |
| winSlotCls | input | 8x2 | Slot class per window entry |
| winResCls | input | 8x3 | Issue-resource class per window entry |
| dispReady | input | 1 | Downstream can accept a group this cycle |
| takeCount | output | 4 | Entries consumed from the window this cycle |
| grpValid | output | 1 | Registered group is valid |
| grpSlotValid | output | 8 | Occupied slots of the registered group |
| grpSlotIdx | output | 8x3 | Owning window index per slot |
| grpUnit | output | 8x8 | Issue-unit mask per accepted window index |

## Verification
The bench targets the alignment cases. A pair that meets an odd slot must skip it; a design that forgot this would show a pair straddling slots 1 and 2. A pair that meets slot 7 must close the group; a wrong design would overflow or wrap. It checks a whole-group op in both first and second position, which exposes a design that shares the group with it. It also runs super-width ops after a partly used execution pool, where a wrong design grabs a split pair such as units 1 and 2. It covers store-both behind a single store and a third load ahead of a fitting execution op. A design that skips over a blocked instruction instead of closing would then take too many entries.

// File: rtl/disp_group_pkg.sv
package disp_group_pkg;

  typedef enum logic [1:0] {
    SLOT_SINGLE = 2'd0,
    SLOT_PAIR   = 2'd1,
    SLOT_WHOLE  = 2'd2,
    SLOT_ALT    = 2'd3
  } slot_cls_e;

  typedef enum logic [2:0] {
    RES_EXEC      = 3'd0,
    RES_EXEC_WIDE = 3'd1,
    RES_LOAD      = 3'd2,
    RES_LOAD_AGEN = 3'd3,
    RES_STORE     = 3'd4,
    RES_STORE_TWO = 3'd5,
    RES_EXEC_6    = 3'd6,
    RES_EXEC_7    = 3'd7
  } res_cls_e;

  // strobes from allocation control to the group register
  typedef struct packed {
    logic load;
    logic idle;
  } grp_strb_t;

endpackage

// File: rtl/disp_group_ctrl.sv
module disp_group_ctrl
  import disp_group_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_EXU   = 4,
  parameter int NUM_LU    = 2,
  parameter int NUM_STU   = 2,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
  localparam int PW       = CNT_W + 1,
  localparam int UNIT_W   = NUM_EXU + NUM_LU + NUM_STU
) (
  input  logic [CNT_W-1:0]                 winCount,
  input  logic [NUM_SLOTS-1:0][1:0]        winSlotCls,
  input  logic [NUM_SLOTS-1:0][2:0]        winResCls,
  input  logic                             dispReady,
  output logic [NUM_SLOTS-1:0]             accept,
  output logic [NUM_SLOTS-1:0][PW-1:0]     startSlot,
  output logic [NUM_SLOTS-1:0][PW-1:0]     needSlots,
  output logic [NUM_SLOTS-1:0][UNIT_W-1:0] unitMask,
  output logic [CNT_W-1:0]                 takeCount,
  output grp_strb_t                        strb
);

  logic [CNT_W-1:0] allocCount;

  always_comb begin : alloc
    logic [PW-1:0]      ptr;
    logic [PW-1:0]      st;
    logic [PW-1:0]      nd;
    logic               stop;
    logic               active;
    logic               slotOk;
    logic               resOk;
    logic [NUM_EXU-1:0] exuFree;
    logic [NUM_LU-1:0]  luFree;
    logic [NUM_STU-1:0] stuFree;
    logic [NUM_EXU-1:0] exuPick;
    logic [NUM_EXU-1:0] widePick;
    logic [NUM_LU-1:0]  luPick;
    logic [NUM_STU-1:0] stuPick;
    logic [NUM_EXU-1:0] exuUse;
    logic [NUM_LU-1:0]  luUse;
    logic [NUM_STU-1:0] stuUse;

    ptr        = '0;
    stop       = 1'b0;
    exuFree    = '1;
    luFree     = '1;
    stuFree    = '1;
    allocCount = '0;
    accept     = '0;
    startSlot  = '0;
    needSlots  = '0;
    unitMask   = '0;

    for (int i = 0; i < NUM_SLOTS; i++) begin
      active = !stop && (i < int'(winCount));

      // slot rule
      case (slot_cls_e'(winSlotCls[i]))
        SLOT_PAIR: begin
          st     = (ptr + PW'(1)) & ~PW'(1);
          nd     = PW'(2);
          slotOk = (st + nd) <= PW'(NUM_SLOTS);
        end
        SLOT_WHOLE: begin
          st     = ptr;
          nd     = PW'(NUM_SLOTS);
          slotOk = (ptr == '0);
        end
        default: begin
          st     = ptr;
          nd     = PW'(1);
          slotOk = (ptr + nd) <= PW'(NUM_SLOTS);
        end
      endcase

      // lowest free unit of each kind
      exuPick  = exuFree & (~exuFree + NUM_EXU'(1));
      luPick   = luFree & (~luFree + NUM_LU'(1));
      stuPick  = stuFree & (~stuFree + NUM_STU'(1));
      widePick = '0;
      for (int p = 0; p < NUM_EXU / 2; p++) begin
        if (widePick == '0 && exuFree[2*p] && exuFree[2*p+1])
          widePick[2*p +: 2] = 2'b11;
      end

      exuUse = '0;
      luUse  = '0;
      stuUse = '0;
      case (res_cls_e'(winResCls[i]))
        RES_EXEC_WIDE: begin
          resOk  = |widePick;
          exuUse = widePick;
        end
        RES_LOAD: begin
          resOk = |luPick;
          luUse = luPick;
        end
        RES_LOAD_AGEN: begin
          resOk  = |luPick && |stuPick;
          luUse  = luPick;
          stuUse = stuPick;
        end
        RES_STORE: begin
          resOk  = |stuPick;
          stuUse = stuPick;
        end
        RES_STORE_TWO: begin
          resOk  = &stuFree;
          stuUse = stuFree;
        end
        default: begin
          resOk  = |exuPick;
          exuUse = exuPick;
        end
      endcase

      if (active && slotOk && resOk) begin
        accept[i]    = 1'b1;
        startSlot[i] = st;
        needSlots[i] = nd;
        unitMask[i]  = {stuUse, luUse, exuUse};
        ptr          = st + nd;
        exuFree      = exuFree & ~exuUse;
        luFree       = luFree & ~luUse;
        stuFree      = stuFree & ~stuUse;
        allocCount   = allocCount + CNT_W'(1);
      end else begin
        stop = 1'b1;
      end
    end
  end

  assign takeCount = dispReady ? allocCount : '0;
  assign strb.load = dispReady && (allocCount != '0);
  assign strb.idle = !strb.load;

endmodule

// File: rtl/disp_group_datapath.sv
module disp_group_datapath
  import disp_group_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int UNIT_W    = 8,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
  localparam int PW       = CNT_W + 1,
  localparam int IW       = $clog2(NUM_SLOTS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  grp_strb_t                        strb,
  input  logic [NUM_SLOTS-1:0]             accept,
  input  logic [NUM_SLOTS-1:0][PW-1:0]     startSlot,
  input  logic [NUM_SLOTS-1:0][PW-1:0]     needSlots,
  input  logic [NUM_SLOTS-1:0][UNIT_W-1:0] unitMask,
  output logic                             grpValid,
  output logic [NUM_SLOTS-1:0]             grpSlotValid,
  output logic [NUM_SLOTS-1:0][IW-1:0]     grpSlotIdx,
  output logic [NUM_SLOTS-1:0][UNIT_W-1:0] grpUnit
);

  logic [NUM_SLOTS-1:0]         mapValid;
  logic [NUM_SLOTS-1:0][IW-1:0] mapIdx;

  // build the slot ownership map, one comparator pair per slot and entry
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_comb begin
      mapValid[s] = 1'b0;
      mapIdx[s]   = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (accept[i] && PW'(s) >= startSlot[i] &&
            PW'(s) < (startSlot[i] + needSlots[i])) begin
          mapValid[s] = 1'b1;
          mapIdx[s]   = IW'(i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.idle) begin
      grpValid     <= 1'b0;
      grpSlotValid <= '0;
      grpSlotIdx   <= '0;
      grpUnit      <= '0;
    end else if (strb.load) begin
      grpValid     <= 1'b1;
      grpSlotValid <= mapValid;
      grpSlotIdx   <= mapIdx;
      grpUnit      <= unitMask;
    end
  end

endmodule

// File: rtl/disp_group_alloc.sv
module disp_group_alloc
  import disp_group_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_EXU   = 4,
  parameter int NUM_LU    = 2,
  parameter int NUM_STU   = 2,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
  localparam int PW       = CNT_W + 1,
  localparam int IW       = $clog2(NUM_SLOTS),
  localparam int UNIT_W   = NUM_EXU + NUM_LU + NUM_STU
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [CNT_W-1:0]                 winCount,
  input  logic [NUM_SLOTS-1:0][1:0]        winSlotCls,
  input  logic [NUM_SLOTS-1:0][2:0]        winResCls,
  input  logic                             dispReady,
  output logic [CNT_W-1:0]                 takeCount,
  output logic                             grpValid,
  output logic [NUM_SLOTS-1:0]             grpSlotValid,
  output logic [NUM_SLOTS-1:0][IW-1:0]     grpSlotIdx,
  output logic [NUM_SLOTS-1:0][UNIT_W-1:0] grpUnit
);

  grp_strb_t                        strb;
  logic [NUM_SLOTS-1:0]             accept;
  logic [NUM_SLOTS-1:0][PW-1:0]     startSlot;
  logic [NUM_SLOTS-1:0][PW-1:0]     needSlots;
  logic [NUM_SLOTS-1:0][UNIT_W-1:0] unitMask;

  disp_group_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_EXU(NUM_EXU), .NUM_LU(NUM_LU), .NUM_STU(NUM_STU)
  ) u_ctrl (
    .winCount  (winCount),
    .winSlotCls(winSlotCls),
    .winResCls (winResCls),
    .dispReady (dispReady),
    .accept    (accept),
    .startSlot (startSlot),
    .needSlots (needSlots),
    .unitMask  (unitMask),
    .takeCount (takeCount),
    .strb      (strb)
  );

  disp_group_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .UNIT_W(UNIT_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .accept      (accept),
    .startSlot   (startSlot),
    .needSlots   (needSlots),
    .unitMask    (unitMask),
    .grpValid    (grpValid),
    .grpSlotValid(grpSlotValid),
    .grpSlotIdx  (grpSlotIdx),
    .grpUnit     (grpUnit)
  );

endmodule

// File: rtl/disp_group_alloc_chk.sv
module disp_group_alloc_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W     = 4,
  parameter int IW        = 3,
  parameter int UNIT_W    = 8
) (
  input logic                             clk,
  input logic                             rst,
  input logic [CNT_W-1:0]                 winCount,
  input logic                             dispReady,
  input logic [CNT_W-1:0]                 takeCount,
  input logic                             grpValid,
  input logic [NUM_SLOTS-1:0]             grpSlotValid,
  input logic [NUM_SLOTS-1:0][IW-1:0]     grpSlotIdx,
  input logic [NUM_SLOTS-1:0][UNIT_W-1:0] grpUnit
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  logic [UNIT_W-1:0] unitUnion;
  int                unitTotal;
  logic              orderOk;

  always_comb begin
    unitUnion = '0;
    unitTotal = 0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      unitUnion = unitUnion | grpUnit[i];
      unitTotal = unitTotal + $countones(grpUnit[i]);
    end
  end

  always_comb begin : order
    logic evenHole;
    int   lastIdx;
    orderOk  = 1'b1;
    evenHole = 1'b0;
    lastIdx  = 0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (grpSlotValid[s]) begin
        if (evenHole || int'(grpSlotIdx[s]) < lastIdx) orderOk = 1'b0;
        lastIdx = int'(grpSlotIdx[s]);
      end else if (s % 2 == 0) begin
        evenHole = 1'b1;
      end
    end
  end

  AST_ALWAYS_PROGRESS: assert property (@(posedge clk) disable iff (rst)
    (dispReady && winCount != '0) |-> takeCount != '0);                 // R11

  AST_TAKE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (takeCount <= winCount) && (dispReady || takeCount == '0));          // R2

  AST_GROUP_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (rst || !armed)
    1'b1 |=> grpValid == ($past(takeCount) != '0));                       // R12

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !grpValid |-> (grpSlotValid == '0 && grpUnit == '0));                 // R12

  AST_NO_UNIT_SHARED: assert property (@(posedge clk) disable iff (rst)
    grpValid |-> $countones(unitUnion) == unitTotal);                     // R6

  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (rst)
    grpValid |-> orderOk);                                                // R4

endmodule

bind disp_group_alloc disp_group_alloc_chk #(
  .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .IW(IW), .UNIT_W(UNIT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .winCount    (winCount),
  .dispReady   (dispReady),
  .takeCount   (takeCount),
  .grpValid    (grpValid),
  .grpSlotValid(grpSlotValid),
  .grpSlotIdx  (grpSlotIdx),
  .grpUnit     (grpUnit)
);

// File: tb/disp_group_alloc_bench.sv
module disp_group_alloc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  localparam logic [1:0] CS = 2'd0, CP = 2'd1, CW = 2'd2, CX = 2'd3;
  localparam logic [2:0] RE = 3'd0, RX = 3'd1, RL = 3'd2, RLS = 3'd3,
                         RS = 3'd4, RSB = 3'd5, RQ = 3'd7;

  typedef struct packed {
    logic [3:0]      cnt;
    logic [7:0][1:0] cls;
    logic [7:0][2:0] res;
    logic [3:0]      take;
    logic [7:0]      slots;
    logic [2:0][7:0] u;      // unit masks of entries 2,1,0
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd8, {8{CS}}, {8{RE}}, 4'd4, 8'h0F, {8'h04, 8'h02, 8'h01}},
    '{4'd8, {8{CS}}, {RE,RE,RE,RE,RS,RS,RL,RL}, 4'd8, 8'hFF, {8'h40, 8'h20, 8'h10}},
    '{4'd3, {CS,CS,CS,CS,CS,CS,CP,CS}, {8{RE}}, 4'd3, 8'h1D, {8'h04, 8'h02, 8'h01}},
    '{4'd2, {CS,CS,CS,CS,CS,CS,CS,CW}, {8{RE}}, 4'd1, 8'hFF, {8'h00, 8'h00, 8'h01}},
    '{4'd2, {CS,CS,CS,CS,CS,CS,CW,CS}, {8{RE}}, 4'd1, 8'h01, {8'h00, 8'h00, 8'h01}},
    '{4'd5, {8{CP}}, {RE,RE,RE,RE,RS,RS,RL,RL}, 4'd4, 8'hFF, {8'h40, 8'h20, 8'h10}},
    '{4'd3, {8{CS}}, {RE,RE,RE,RE,RE,RX,RX,RX}, 4'd2, 8'h03, {8'h00, 8'h0C, 8'h03}},
    '{4'd4, {8{CS}}, {RE,RE,RE,RE,RE,RE,RX,RE}, 4'd3, 8'h07, {8'h02, 8'h0C, 8'h01}},
    '{4'd4, {8{CS}}, {RE,RE,RE,RE,RX,RE,RE,RE}, 4'd3, 8'h07, {8'h04, 8'h02, 8'h01}},
    '{4'd3, {8{CS}}, {RE,RE,RE,RE,RE,RLS,RLS,RLS}, 4'd2, 8'h03, {8'h00, 8'hA0, 8'h50}},
    '{4'd2, {8{CS}}, {RE,RE,RE,RE,RE,RE,RS,RSB}, 4'd1, 8'h01, {8'h00, 8'h00, 8'hC0}},
    '{4'd2, {8{CS}}, {RE,RE,RE,RE,RE,RE,RSB,RS}, 4'd1, 8'h01, {8'h00, 8'h00, 8'h40}},
    '{4'd4, {8{CS}}, {RE,RE,RE,RE,RE,RL,RL,RL}, 4'd2, 8'h03, {8'h00, 8'h20, 8'h10}},
    '{4'd0, {8{CS}}, {8{RE}}, 4'd0, 8'h00, {8'h00, 8'h00, 8'h00}},
    '{4'd8, {CP,CS,CS,CS,CS,CS,CS,CS}, {RE,RE,RE,RE,RS,RS,RL,RL}, 4'd7, 8'h7F, {8'h40, 8'h20, 8'h10}},
    '{4'd2, {8{CS}}, {8{RE}}, 4'd2, 8'h03, {8'h00, 8'h02, 8'h01}},
    '{4'd5, {8{CX}}, {8{RQ}}, 4'd4, 8'h0F, {8'h04, 8'h02, 8'h01}}
  };

  logic                 clk = 1'b0;
  logic                 rst;
  logic [3:0]           winCount;
  logic [7:0][1:0]      winSlotCls;
  logic [7:0][2:0]      winResCls;
  logic                 dispReady;
  logic [3:0]           takeCount;
  logic                 grpValid;
  logic [7:0]           grpSlotValid;
  logic [7:0][2:0]      grpSlotIdx;
  logic [7:0][7:0]      grpUnit;

  int nTests = 0;
  int nFail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  disp_group_alloc u_disp_group_alloc (
    .clk(clk), .rst(rst), .winCount(winCount), .winSlotCls(winSlotCls),
    .winResCls(winResCls), .dispReady(dispReady), .takeCount(takeCount),
    .grpValid(grpValid), .grpSlotValid(grpSlotValid), .grpSlotIdx(grpSlotIdx),
    .grpUnit(grpUnit)
  );

  function automatic string tagOf(int k);
    case (k)
      0: return "R6";   1: return "R8";   2: return "R4";   3: return "R5";
      4: return "R5";   5: return "R4";   6: return "R7";   7: return "R7";
      8: return "R7";   9: return "R8";  10: return "R9";  11: return "R9";
     12: return "R10"; 13: return "R2";  14: return "R4";  15: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v, logic rdy);
    winCount   = v.cnt;
    winSlotCls = v.cls;
    winResCls  = v.res;
    dispReady  = rdy;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(VECS[0], 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "grpValid after reset", int'(grpValid), 0);
    check("R1", "grpSlotValid after reset", int'(grpSlotValid), 0);
    check("R1", "grpUnit after reset", int'(grpUnit != '0), 0);
    check("R1", "grpSlotIdx after reset", int'(grpSlotIdx != '0), 0);
    rst = 1'b0;

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      drive(VECS[k], 1'b1);
      #1;
      check(tagOf(k), $sformatf("vec%0d takeCount", k), int'(takeCount), int'(VECS[k].take));
      if (VECS[k].cnt != 0)
        check("R11", $sformatf("vec%0d progress", k), int'(takeCount != 0), 1);
      @(posedge clk);
      @(negedge clk);
      check("R12", $sformatf("vec%0d grpValid", k), int'(grpValid), int'(VECS[k].take != 0));
      check(tagOf(k), $sformatf("vec%0d slots", k), int'(grpSlotValid), int'(VECS[k].slots));
      for (int j = 0; j < 3; j++)
        check(tagOf(k), $sformatf("vec%0d unit of entry %0d", k, j),
              int'(grpUnit[j]), int'(VECS[k].u[j]));
    end

    // R3: owner index per slot for single, pair and single after a skipped odd slot
    drive(VECS[2], 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R3", "slot0 owner", int'(grpSlotIdx[0]), 0);
    check("R3", "slot2 owner", int'(grpSlotIdx[2]), 1);
    check("R3", "slot3 owner", int'(grpSlotIdx[3]), 1);
    check("R3", "slot4 owner", int'(grpSlotIdx[4]), 2);

    // R2 / R12: not ready takes nothing and shows no group
    drive(VECS[0], 1'b0);
    #1;
    check("R2", "takeCount while not ready", int'(takeCount), 0);
    @(posedge clk);
    @(negedge clk);
    check("R12", "grpValid after not-ready cycle", int'(grpValid), 0);
    check("R12", "slots after not-ready cycle", int'(grpSlotValid), 0);

    // R1: reset in the middle of traffic wins over a capture
    drive(VECS[1], 1'b1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "grpValid under reset", int'(grpValid), 0);
    check("R1", "slots under reset", int'(grpSlotValid), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R12", "group after reset release", int'(grpSlotValid), 8'hFF);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule